// File: doc/BRIEF.md
# Dual-Standard FSK Tone Generator

This block produces the digital carrier for a 300-baud frequency-shift-keyed modem. It runs from a 3.579545 MHz reference clock. A fixed divider turns that clock into a sample strobe of about 77.8 kHz. On each strobe a 24-bit phase accumulator advances by an increment chosen from the transmit bit, the channel select and the signalling standard (Bell 103 or V.21). A quarter-wave sine table then turns the top phase bits into a signed 8-bit sample.

Changing tone only swaps the increment, so the waveform stays phase-continuous across bit boundaries. An echo-tone request replaces the data tones with a fixed tone whose pitch depends on the standard. Squelch silences the samples while the strobe and the phase keep running. Loopback together with squelch is power-down: the strobe stops, the output is held at zero and the phase is frozen. The samples feed an external smoothing filter and line driver.

Top module: `fsk_mod`

## Requirements
- R1: While reset is asserted, and on leaving it, `sample_o` is 0 and `valid_o` is 0.
- R2: Outside power-down, `valid_o` is a one-cycle pulse every SAMPLE_DIV (46) clocks.
- R3: The sample issued on a strobe is round(127·sin(2π(p+0.5)/1024)), as signed two's complement, where p is bits 23:14 of the accumulator before that strobe's advance. The value -128 never appears. `sample_o` changes only on a strobe or on entry to power-down.
- R4: With `v21_i`=0 and `orig_i`=1, `tx_data_i`=1 (mark) gives 1270 Hz and `tx_data_i`=0 (space) gives 1070 Hz.
- R5: With `v21_i`=0 and `orig_i`=0, mark gives 2225 Hz and space gives 2025 Hz.
- R6: With `v21_i`=1 and `orig_i`=1, mark gives 980 Hz and space gives 1180 Hz.
- R7: With `v21_i`=1 and `orig_i`=0, mark gives 1650 Hz and space gives 1850 Hz.
- R8: While `echo_i`=1, the tone is 2100 Hz if `v21_i`=1 and 2225 Hz if `v21_i`=0, whatever `tx_data_i` and `orig_i` are.
- R9: While `squelch_i`=1 and `loopback_i`=0, every sample is 0. This takes priority over echo. Strobes continue and the phase keeps advancing.
- R10: While `loopback_i`=1 and `squelch_i`=1, no strobe occurs, `sample_o` is 0 and the phase is held. On exit, output resumes from the held phase.
- R11: A tone change never resets the accumulator, so the phase is continuous across the change.
- R12: Each increment is round(f·2^24·SAMPLE_DIV/CLK_HZ). At the default clock this puts every tone within 5 Hz of nominal.
- R13: `loopback_i` alone, with `squelch_i`=0, has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, nominally 3.579545 MHz |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_data_i | input | 1 | Transmit bit: 1 is mark, 0 is space |
| orig_i | input | 1 | 1 selects originate / channel 1, 0 selects answer / channel 2 |
| v21_i | input | 1 | 1 selects the V.21 tone plan, 0 selects Bell 103 |
| squelch_i | input | 1 | Mutes the samples |
| echo_i | input | 1 | Requests the fixed echo tone |
| loopback_i | input | 1 | Loopback request; with squelch_i it means power-down |
| sample_o | output | 8 | Signed sine sample |
| valid_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
A wrong increment or a phase that jumps at a tone change is visible on `sample_o` within a few samples. The sample stream then leaves the sine trajectory that a free-running reference accumulator predicts, and the error grows with every later strobe. A faulty divider count shows up at the first gap between strobes. Leaking the mute or power-down state shows up as a nonzero sample, or a stray strobe, on the very next strobe slot.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  typedef enum logic [3:0] {
    T_B_OS, T_B_OM, T_B_AS, T_B_AM,
    T_V_1S, T_V_1M, T_V_2S, T_V_2M,
    T_ECHO_B, T_ECHO_V
  } tone_e;

  localparam int NUM_TONES = 10;

  function automatic longint tone_hz(input int t);
    case (t)
      0: return 1070;  1: return 1270;
      2: return 2025;  3: return 2225;
      4: return 1180;  5: return 980;
      6: return 1850;  7: return 1650;
      8: return 2225;  9: return 2100;
      default: return 0;
    endcase
  endfunction

  // rounded phase step per sample for a tone
  function automatic longint calc_inc(input longint f, input longint clk_hz,
                                      input longint div, input int acc_w);
    return ((f << acc_w) * div + clk_hz / 2) / clk_hz;
  endfunction
endpackage

// File: rtl/fsk_tick_gen.sv
module fsk_tick_gen #(
  parameter int DIV = 46
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i)           cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fsk_inc_sel.sv
module fsk_inc_sel
  import fsk_pkg::*;
#(
  parameter longint CLK_HZ     = 3579545,
  parameter int     SAMPLE_DIV = 46,
  parameter int     ACC_W      = 24
) (
  input  logic             data_i,
  input  logic             orig_i,
  input  logic             v21_i,
  input  logic             echo_i,
  output logic [ACC_W-1:0] inc_o
);
  logic [ACC_W-1:0] inc_tab [NUM_TONES];

  for (genvar i = 0; i < NUM_TONES; i++) begin : g_inc
    localparam longint STEP = calc_inc(tone_hz(i), CLK_HZ, longint'(SAMPLE_DIV), ACC_W);
    assign inc_tab[i] = STEP[ACC_W-1:0];
  end

  tone_e sel;

  always_comb begin
    if (echo_i) sel = v21_i ? T_ECHO_V : T_ECHO_B;
    else        sel = tone_e'({1'b0, v21_i, ~orig_i, data_i});
    inc_o = inc_tab[sel];
  end
endmodule

// File: rtl/fsk_sine_lut.sv
module fsk_sine_lut #(
  parameter int LUT_AW = 8,
  parameter int OUT_W  = 8
) (
  input  logic [LUT_AW+1:0]        phase_i,
  output logic signed [OUT_W-1:0]  sample_o
);
  localparam int DEPTH = 1 << LUT_AW;
  localparam int FULL  = 4 * DEPTH;
  localparam int PEAK  = (1 << (OUT_W - 1)) - 1;

  typedef logic [OUT_W-2:0] qtab_t [DEPTH];

  // half-step offset makes the quarter fold exact
  function automatic qtab_t build_tab();
    qtab_t t;
    for (int i = 0; i < DEPTH; i++) begin
      real a;
      int  v;
      a = 2.0 * 3.141592653589793 * (real'(i) + 0.5) / real'(FULL);
      v = $rtoi($sin(a) * real'(PEAK) + 0.5);
      t[i] = v[OUT_W-2:0];
    end
    return t;
  endfunction

  localparam qtab_t QTAB = build_tab();

  logic [LUT_AW-1:0] addr;
  logic [OUT_W-2:0]  mag;
  logic signed [OUT_W-1:0] pos;

  always_comb begin
    addr = phase_i[LUT_AW] ? ~phase_i[LUT_AW-1:0] : phase_i[LUT_AW-1:0];
    mag  = QTAB[addr];
    pos  = signed'({1'b0, mag});
    sample_o = phase_i[LUT_AW+1] ? -pos : pos;
  end
endmodule

// File: rtl/fsk_mod.sv
module fsk_mod #(
  parameter longint CLK_HZ     = 3579545,
  parameter int     SAMPLE_DIV = 46,
  parameter int     ACC_W      = 24,
  parameter int     LUT_AW     = 8,
  parameter int     OUT_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_data_i,
  input  logic             orig_i,
  input  logic             v21_i,
  input  logic             squelch_i,
  input  logic             echo_i,
  input  logic             loopback_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             valid_o
);
  localparam int PH_W = LUT_AW + 2;

  logic             pwr_dn;
  logic             tick;
  logic [ACC_W-1:0] inc;
  logic [ACC_W-1:0] acc_q;
  logic signed [OUT_W-1:0] lut_val;

  assign pwr_dn = loopback_i & squelch_i;

  fsk_tick_gen #(.DIV(SAMPLE_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (~pwr_dn),
    .tick_o (tick)
  );

  fsk_inc_sel #(.CLK_HZ(CLK_HZ), .SAMPLE_DIV(SAMPLE_DIV), .ACC_W(ACC_W)) u_inc (
    .data_i (tx_data_i),
    .orig_i (orig_i),
    .v21_i  (v21_i),
    .echo_i (echo_i),
    .inc_o  (inc)
  );

  fsk_sine_lut #(.LUT_AW(LUT_AW), .OUT_W(OUT_W)) u_lut (
    .phase_i  (acc_q[ACC_W-1 -: PH_W]),
    .sample_o (lut_val)
  );

  // sample reflects phase before this tick's advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= tick;
      if (tick) acc_q <= acc_q + inc;
      if (pwr_dn)    sample_o <= '0;
      else if (tick) sample_o <= squelch_i ? '0 : lut_val;
    end
  end
endmodule

// File: rtl/fsk_mod_chk.sv
module fsk_mod_chk #(
  parameter int SAMPLE_DIV = 46,
  parameter int OUT_W      = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             squelch_i,
  input logic             loopback_i,
  input logic [OUT_W-1:0] sample_o,
  input logic             valid_o
);
  localparam int PEAK = (1 << (OUT_W - 1)) - 1;

  logic        pd;
  logic        seen_q;
  logic [15:0] gap_q;

  assign pd = loopback_i & squelch_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else if (pd) begin
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else if (valid_o) begin
      seen_q <= 1'b1;
      gap_q  <= 16'd1;
    end else if (gap_q != 16'hffff) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  p_valid_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && seen_q && !pd) |-> (gap_q == 16'(SAMPLE_DIV)));

  p_mag_limit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $signed(sample_o) >= -PEAK);

  p_sample_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !$past(pd)) |-> $stable(sample_o));

  p_mute_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(squelch_i)) |-> (sample_o == '0));

  p_pd_silent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pd) |-> (!valid_o && sample_o == '0));
endmodule

bind fsk_mod fsk_mod_chk #(.SAMPLE_DIV(SAMPLE_DIV), .OUT_W(OUT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .squelch_i  (squelch_i),
  .loopback_i (loopback_i),
  .sample_o   (sample_o),
  .valid_o    (valid_o)
);

// File: tb/fsk_mod_tb.sv
`timescale 1ns/1ps
module fsk_mod_tb_top;
  localparam int    DIV  = 46;
  localparam real   CLKR = 3579545.0;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_data_i = 1'b0, orig_i = 1'b1, v21_i = 1'b0;
  logic squelch_i = 1'b0, echo_i = 1'b0, loopback_i = 1'b0;
  logic [7:0] sample_o;
  logic valid_o;

  int checks = 0, fails = 0, mon_cnt = 0;
  int exp_q[$];
  string tag_q[$];
  longint m_acc = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  fsk_mod dut_i (
    .clk_i, .rst_ni, .tx_data_i, .orig_i, .v21_i,
    .squelch_i, .echo_i, .loopback_i, .sample_o, .valid_o
  );

  function automatic int rnd(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic real pick_hz(bit d, bit o, bit v, bit e);
    if (e) return v ? 2100.0 : 2225.0;
    if (!v) return o ? (d ? 1270.0 : 1070.0) : (d ? 2225.0 : 2025.0);
    return o ? (d ? 980.0 : 1180.0) : (d ? 1650.0 : 1850.0);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: apply inputs, push expected samples
  task automatic seg(bit d, bit o, bit v, bit sq, bit e, bit lb, int n, string req);
    longint inc;
    int target;
    tx_data_i = d; orig_i = o; v21_i = v; squelch_i = sq; echo_i = e; loopback_i = lb;
    inc = longint'(rnd(pick_hz(d, o, v, e) * 16777216.0 * real'(DIV) / CLKR));
    for (int i = 0; i < n; i++) begin
      int p;
      p = int'(m_acc >> 14);
      exp_q.push_back(sq ? 0 : rnd(127.0 * $sin(2.0 * 3.141592653589793 * (real'(p) + 0.5) / 1024.0)));
      tag_q.push_back(req);
      m_acc = (m_acc + inc) & 64'hFFFFFF;
    end
    target = mon_cnt + n;
    wait (mon_cnt == target);
    @(negedge clk_i);
  endtask

  // monitor
  int cyc = 0, last_v = -1;
  always @(posedge clk_i) begin
    #2;
    cyc++;
    if (loopback_i && squelch_i) last_v = -1;
    if (rst_ni && valid_o) begin
      if (last_v >= 0) check(cyc - last_v == DIV, "R2", cyc - last_v, DIV);
      last_v = cyc;
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected strobe", 1, 0);
      end else begin
        int e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = int'($signed(sample_o));
        check((a - e <= 1) && (e - a <= 1), t, a, e);
      end
      mon_cnt++;
    end
  end

  initial begin
    #(2_000_000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk_i);
    check(sample_o == 8'd0, "R1 sample", int'(sample_o), 0);
    check(valid_o == 1'b0, "R1 valid", int'(valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(sample_o == 8'd0 && !valid_o, "R1 after release", int'(sample_o), 0);

    seg(0, 1, 0, 0, 0, 0, 40, "R4 space R3");
    seg(1, 1, 0, 0, 0, 0, 40, "R4 mark R11");
    seg(0, 0, 0, 0, 0, 0, 30, "R5 space");
    seg(1, 0, 0, 0, 0, 0, 30, "R5 mark R11");
    seg(0, 1, 1, 0, 0, 0, 30, "R6 space");
    seg(1, 1, 1, 0, 0, 0, 30, "R6 mark");
    seg(0, 0, 1, 0, 0, 0, 30, "R7 space");
    seg(1, 0, 1, 0, 0, 0, 30, "R7 mark");
    seg(0, 1, 1, 0, 1, 0, 25, "R8 echo v21");
    seg(1, 0, 1, 0, 1, 0, 25, "R8 echo v21 data");
    seg(1, 1, 0, 0, 1, 0, 25, "R8 echo bell");
    seg(0, 0, 0, 0, 1, 0, 25, "R8 echo bell data");
    seg(1, 1, 0, 1, 1, 0, 20, "R9 squelch");
    seg(0, 1, 0, 0, 0, 1, 30, "R13 loopback alone");

    // power-down: no strobe, zero output, phase held
    squelch_i = 1'b1; loopback_i = 1'b1;
    repeat (150) begin
      @(negedge clk_i);
      check(!valid_o, "R10 strobe", int'(valid_o), 0);
    end
    check(sample_o == 8'd0, "R10 sample", int'(sample_o), 0);
    seg(1, 0, 1, 0, 0, 0, 60, "R10 resume R12");

    done = 1;
    check(exp_q.size() == 0, "R3 leftover", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule